// File: doc/BRIEF.md
# Trap Delegation and Privilege Unit

This block sits beside the trap logic of a three-level core (user, supervisor, machine). For every trap it receives, it states whether the machine level or the supervisor level handles it. It makes that choice from two per-cause bitmasks, one for synchronous exceptions and one for interrupts. Both masks live here and are loaded through a small register write port. The same port also loads the machine interrupt-enable register.

The block presents supervisor-level views of the interrupt-enable and interrupt-pending state. These views expose only the bits delegated to the supervisor. A supervisor write to the enable view can only touch those delegated bits. A small decoder checks the running privilege against each machine-return instruction and each control-register access. It raises an illegal-instruction flag when lower-privilege code reaches for machine-only resources. The core feeds this flag into its own exception path.

Top module: `trap_route_unit`

## Requirements
- R1: After the asynchronous reset, the exception-delegation mask, the interrupt-delegation mask and the machine interrupt-enable register read as zero. A trap from any privilege is therefore routed to machine mode (target_priv_o = 2'b11).
- R2: A valid exception (trap_irq_i = 0) raised from user (2'b00) or supervisor (2'b01) is routed to supervisor (2'b01) when bit trap_cause_i of the exception-delegation mask is 1. Otherwise it goes to machine (2'b11).
- R3: A valid interrupt (trap_irq_i = 1) raised from user or supervisor is routed to supervisor when bit trap_cause_i of the interrupt-delegation mask is 1. Otherwise it goes to machine. The exception mask plays no part in this decision.
- R4: A trap raised while in machine mode (priv_i = 2'b11) always targets machine, whatever the masks hold.
- R5: s_irq_en_o equals the machine interrupt-enable register ANDed with the interrupt-delegation mask. s_irq_pend_o equals irq_pending_i ANDed with the same mask. Undelegated bits read as zero.
- R6: csr_sel_i selects the register written when csr_we_i = 1: 2'b00 exception mask, 2'b01 interrupt mask, 2'b10 machine interrupt-enable (all bits), 2'b11 supervisor interrupt-enable. A supervisor-enable write changes only the delegated bits of the machine interrupt-enable register and leaves the others unchanged.
- R7: A register write becomes visible in the cycle after the write strobe. The target output is combinational and valid in the same cycle as trap_valid_i.
- R8: mret_i raises illegal_instr_o when priv_i is supervisor or user, and not in machine mode.
- R9: On a control-register access, address bits [9:8] give the required level: 00 user, 01 supervisor, 10 reserved above supervisor, 11 machine. The access raises illegal_instr_o when that level exceeds priv_i. Machine mode may access every level. With neither mret_i nor csr_access_i set, illegal_instr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trap_valid_i | input | 1 | A trap is being taken this cycle |
| trap_irq_i | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause_i | input | 5 | Cause code, indexes the delegation masks |
| priv_i | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| target_priv_o | output | 2 | Privilege that handles the trap (11 when no trap) |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 2 | Write target select (see R6) |
| csr_wdata_i | input | 32 | Write data |
| irq_pending_i | input | 32 | Machine interrupt-pending lines |
| exc_deleg_o | output | 32 | Exception-delegation mask |
| irq_deleg_o | output | 32 | Interrupt-delegation mask |
| m_irq_en_o | output | 32 | Machine interrupt-enable register |
| s_irq_en_o | output | 32 | Supervisor view of interrupt enable |
| s_irq_pend_o | output | 32 | Supervisor view of interrupt pending |
| mret_i | input | 1 | Machine-return instruction in execute |
| csr_access_i | input | 1 | Control-register access in execute |
| csr_addr_i | input | 12 | Address of that access |
| illegal_instr_o | output | 1 | Privilege violation detected |

## Verification
A corrupted delegation mask shows at the ports within one cycle. Any trap whose cause bit is wrong lands on the wrong target in the same cycle it is raised. The supervisor enable and pending views drop or leak bits at the same moment. A bad masked write of the enable register shows on m_irq_en_o one cycle later, as a changed undelegated bit. The bench therefore probes each mask bit it sets, plus an undelegated neighbour, from every privilege. It also covers cause 31 and cause 0 at the edges of the masks. A decoder fault appears at once on illegal_instr_o for the affected privilege and address level.

// File: rtl/trap_route_pkg.sv
package trap_route_pkg;
  localparam int unsigned XLEN       = 32;
  localparam int unsigned CAUSE_W    = $clog2(XLEN);
  localparam int unsigned CSR_ADDR_W = 12;
  localparam int unsigned CSR_LVL_LO = 8;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_R = 2'b10,
    PRIV_M = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    SEL_EXC_DELEG = 2'b00,
    SEL_IRQ_DELEG = 2'b01,
    SEL_M_IRQ_EN  = 2'b10,
    SEL_S_IRQ_EN  = 2'b11
  } csr_sel_e;
endpackage

// File: rtl/deleg_regs.sv
module deleg_regs
  import trap_route_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  csr_sel_e     sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] exc_deleg_o,
  output logic [W-1:0] irq_deleg_o,
  output logic [W-1:0] m_irq_en_o
);
  logic [W-1:0] exc_q, irq_q, ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_q <= '0;
      irq_q <= '0;
    end else if (we_i) begin
      if (sel_i == SEL_EXC_DELEG) exc_q <= wdata_i;
      if (sel_i == SEL_IRQ_DELEG) irq_q <= wdata_i;
    end
  end

  // enable register: full write from machine view, masked write from supervisor view
  for (genvar i = 0; i < W; i++) begin : g_ie_bit
    logic upd;
    assign upd = we_i && ((sel_i == SEL_M_IRQ_EN) ||
                          (sel_i == SEL_S_IRQ_EN && irq_q[i]));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  ie_q[i] <= 1'b0;
      else if (upd) ie_q[i] <= wdata_i[i];
    end
  end

  assign exc_deleg_o = exc_q;
  assign irq_deleg_o = irq_q;
  assign m_irq_en_o  = ie_q;

  p_deleg_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_IRQ_DELEG) |=> irq_q == $past(wdata_i));
endmodule

// File: rtl/trap_router.sv
module trap_router
  import trap_route_pkg::*;
#(
  parameter int unsigned W  = XLEN,
  parameter int unsigned CW = CAUSE_W
) (
  input  logic          valid_i,
  input  logic          irq_i,
  input  logic [CW-1:0] cause_i,
  input  priv_e         priv_i,
  input  logic [W-1:0]  exc_deleg_i,
  input  logic [W-1:0]  irq_deleg_i,
  output priv_e         target_o
);
  logic deleg_bit;
  logic below_m;

  assign deleg_bit = irq_i ? irq_deleg_i[cause_i] : exc_deleg_i[cause_i];
  assign below_m   = (priv_i == PRIV_U) || (priv_i == PRIV_S);

  always_comb begin
    target_o = PRIV_M;
    if (valid_i && below_m && deleg_bit) target_o = PRIV_S;
  end
endmodule

// File: rtl/csr_priv_check.sv
module csr_priv_check
  import trap_route_pkg::*;
#(
  parameter int unsigned AW     = CSR_ADDR_W,
  parameter int unsigned LVL_LO = CSR_LVL_LO
) (
  input  priv_e         priv_i,
  input  logic          mret_i,
  input  logic          access_i,
  input  logic [AW-1:0] addr_i,
  output logic          illegal_o
);
  logic [1:0] need_lvl;
  logic       mret_bad, csr_bad;

  assign need_lvl = addr_i[LVL_LO+1:LVL_LO];
  assign mret_bad = mret_i && (priv_i != PRIV_M);
  assign csr_bad  = access_i && (need_lvl > priv_i);
  assign illegal_o = mret_bad || csr_bad;
endmodule

// File: rtl/trap_route_unit.sv
module trap_route_unit
  import trap_route_pkg::*;
#(
  parameter int unsigned W  = XLEN,
  parameter int unsigned CW = CAUSE_W,
  parameter int unsigned AW = CSR_ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trap_valid_i,
  input  logic          trap_irq_i,
  input  logic [CW-1:0] trap_cause_i,
  input  logic [1:0]    priv_i,
  output logic [1:0]    target_priv_o,
  input  logic          csr_we_i,
  input  logic [1:0]    csr_sel_i,
  input  logic [W-1:0]  csr_wdata_i,
  input  logic [W-1:0]  irq_pending_i,
  output logic [W-1:0]  exc_deleg_o,
  output logic [W-1:0]  irq_deleg_o,
  output logic [W-1:0]  m_irq_en_o,
  output logic [W-1:0]  s_irq_en_o,
  output logic [W-1:0]  s_irq_pend_o,
  input  logic          mret_i,
  input  logic          csr_access_i,
  input  logic [AW-1:0] csr_addr_i,
  output logic          illegal_instr_o
);
  priv_e        priv;
  priv_e        target;
  logic [W-1:0] exc_deleg, irq_deleg, m_ie;

  assign priv = priv_e'(priv_i);

  deleg_regs #(.W(W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (csr_we_i),
    .sel_i       (csr_sel_e'(csr_sel_i)),
    .wdata_i     (csr_wdata_i),
    .exc_deleg_o (exc_deleg),
    .irq_deleg_o (irq_deleg),
    .m_irq_en_o  (m_ie)
  );

  trap_router #(.W(W), .CW(CW)) u_router (
    .valid_i     (trap_valid_i),
    .irq_i       (trap_irq_i),
    .cause_i     (trap_cause_i),
    .priv_i      (priv),
    .exc_deleg_i (exc_deleg),
    .irq_deleg_i (irq_deleg),
    .target_o    (target)
  );

  csr_priv_check #(.AW(AW)) u_chk (
    .priv_i    (priv),
    .mret_i    (mret_i),
    .access_i  (csr_access_i),
    .addr_i    (csr_addr_i),
    .illegal_o (illegal_instr_o)
  );

  assign target_priv_o = target;
  assign exc_deleg_o   = exc_deleg;
  assign irq_deleg_o   = irq_deleg;
  assign m_irq_en_o    = m_ie;
  assign s_irq_en_o    = m_ie & irq_deleg;
  assign s_irq_pend_o  = irq_pending_i & irq_deleg;

  p_exc_route_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && !trap_irq_i && priv_i != 2'b11 && priv_i != 2'b10 &&
     exc_deleg[trap_cause_i]) |-> target_priv_o == 2'b01);

  p_mmode_keeps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && priv_i == 2'b11) |-> target_priv_o == 2'b11);

  p_sie_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_sel_i == 2'b11) |=>
      ((m_ie ^ $past(m_ie)) & ~$past(irq_deleg)) == '0);

  p_mret_illegal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mret_i && priv_i == 2'b01) |-> illegal_instr_o);

  p_mcsr_from_s_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_access_i && priv_i == 2'b01 && csr_addr_i[9:8] == 2'b11) |-> illegal_instr_o);
endmodule

// File: tb/sim_trap_route_unit.sv
`timescale 1ns/1ps
module sim_trap_route_unit;
  typedef struct {
    int          req;
    int          fld;
    logic [31:0] exp;
  } item_t;

  localparam int F_TGT = 0, F_ILL = 1, F_SIE = 2, F_SIP = 3,
                 F_MIE = 4, F_EDG = 5, F_IDG = 6;

  logic        clk = 0, rst_n = 0;
  logic        trap_valid = 0, trap_irq = 0;
  logic [4:0]  trap_cause = '0;
  logic [1:0]  priv = 2'b11;
  logic [1:0]  target;
  logic        csr_we = 0;
  logic [1:0]  csr_sel = '0;
  logic [31:0] csr_wdata = '0, irq_pend = '0;
  logic [31:0] exc_deleg, irq_deleg, m_ie, s_ie, s_ip;
  logic        mret = 0, csr_acc = 0;
  logic [11:0] csr_addr = '0;
  logic        illegal;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trap_route_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .trap_valid_i(trap_valid), .trap_irq_i(trap_irq), .trap_cause_i(trap_cause),
    .priv_i(priv), .target_priv_o(target),
    .csr_we_i(csr_we), .csr_sel_i(csr_sel), .csr_wdata_i(csr_wdata),
    .irq_pending_i(irq_pend),
    .exc_deleg_o(exc_deleg), .irq_deleg_o(irq_deleg), .m_irq_en_o(m_ie),
    .s_irq_en_o(s_ie), .s_irq_pend_o(s_ip),
    .mret_i(mret), .csr_access_i(csr_acc), .csr_addr_i(csr_addr),
    .illegal_instr_o(illegal)
  );

  function automatic logic [31:0] actual(int fld);
    case (fld)
      F_TGT:   return {30'd0, target};
      F_ILL:   return {31'd0, illegal};
      F_SIE:   return s_ie;
      F_SIP:   return s_ip;
      F_MIE:   return m_ie;
      F_EDG:   return exc_deleg;
      default: return irq_deleg;
    endcase
  endfunction

  // monitor: compares queued expectations away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = actual(it.fld);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL R%0d field %0d actual %h expected %h", it.req, it.fld, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(int req, int fld, logic [31:0] exp);
    item_t it;
    it.req = req; it.fld = fld; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic route(int req, logic irq, logic [4:0] cause, logic [1:0] p, logic [1:0] exp);
    @(negedge clk);
    trap_valid = 1; trap_irq = irq; trap_cause = cause; priv = p;
    expect_val(req, F_TGT, {30'd0, exp});
    @(negedge clk);
    trap_valid = 0;
  endtask

  task automatic csr_write(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    csr_we = 1; csr_sel = sel; csr_wdata = d;
    @(negedge clk);
    csr_we = 0;
  endtask

  task automatic chk_ill(int req, logic [1:0] p, logic m, logic a, logic [11:0] addr, logic exp);
    @(negedge clk);
    priv = p; mret = m; csr_acc = a; csr_addr = addr;
    expect_val(req, F_ILL, {31'd0, exp});
    @(negedge clk);
    mret = 0; csr_acc = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk);
    expect_val(1, F_EDG, 32'h0);
    expect_val(1, F_IDG, 32'h0);
    expect_val(1, F_MIE, 32'h0);
    route(1, 0, 5'd8, 2'b00, 2'b11);
    route(1, 1, 5'd5, 2'b01, 2'b11);

    // R7: write not visible in strobe cycle, visible after
    @(negedge clk);
    csr_we = 1; csr_sel = 2'b00; csr_wdata = 32'h0000_0100;
    expect_val(7, F_EDG, 32'h0);
    @(negedge clk);
    csr_we = 0;
    expect_val(7, F_EDG, 32'h0000_0100);

    // R2 exception routing
    route(2, 0, 5'd8, 2'b00, 2'b01);
    route(2, 0, 5'd8, 2'b01, 2'b01);
    route(2, 0, 5'd2, 2'b00, 2'b11);
    route(4, 0, 5'd8, 2'b11, 2'b11);

    // R3 interrupt routing
    csr_write(2'b01, 32'h0000_0222);
    expect_val(7, F_IDG, 32'h0000_0222);
    route(3, 1, 5'd5, 2'b01, 2'b01);
    route(3, 1, 5'd9, 2'b00, 2'b01);
    route(3, 1, 5'd7, 2'b00, 2'b11);
    route(3, 1, 5'd8, 2'b00, 2'b11);   // exception mask bit 8 set, irq mask clear
    route(2, 0, 5'd5, 2'b00, 2'b11);   // irq mask bit 5 set, exception mask clear
    route(4, 1, 5'd9, 2'b11, 2'b11);

    // cause boundaries
    csr_write(2'b00, 32'h8000_0100);
    route(2, 0, 5'd31, 2'b00, 2'b01);
    route(2, 0, 5'd0, 2'b01, 2'b11);

    // R5 / R6 views and masked write
    irq_pend = 32'h0000_0FFF;
    csr_write(2'b10, 32'h0000_0AAA);
    expect_val(6, F_MIE, 32'h0000_0AAA);
    expect_val(5, F_SIE, 32'h0000_0222);
    expect_val(5, F_SIP, 32'h0000_0222);
    csr_write(2'b11, 32'h0000_0000);
    expect_val(6, F_MIE, 32'h0000_0888);
    expect_val(5, F_SIE, 32'h0000_0000);
    csr_write(2'b10, 32'h0000_0000);
    csr_write(2'b11, 32'hFFFF_FFFF);
    expect_val(6, F_MIE, 32'h0000_0222);
    irq_pend = 32'hFFFF_F000;
    @(negedge clk);
    expect_val(5, F_SIP, 32'h0000_0000);

    // R8 machine return
    chk_ill(8, 2'b01, 1, 0, 12'h000, 1);
    chk_ill(8, 2'b00, 1, 0, 12'h000, 1);
    chk_ill(8, 2'b11, 1, 0, 12'h000, 0);

    // R9 register privilege decode
    chk_ill(9, 2'b01, 0, 1, 12'h300, 1);
    chk_ill(9, 2'b01, 0, 1, 12'h200, 1);
    chk_ill(9, 2'b01, 0, 1, 12'h100, 0);
    chk_ill(9, 2'b01, 0, 1, 12'hC00, 0);
    chk_ill(9, 2'b00, 0, 1, 12'h100, 1);
    chk_ill(9, 2'b00, 0, 1, 12'h300, 1);
    chk_ill(9, 2'b00, 0, 1, 12'hC00, 0);
    chk_ill(9, 2'b11, 0, 1, 12'h300, 0);
    chk_ill(9, 2'b00, 0, 0, 12'h300, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule